// File: doc/BRIEF.md
# Wide Cycle Counter with Coherent Split Readout

The block keeps a free-running cycle counter twice as wide as its register port and lets software read it as a lower and an upper word through a small register window. Because the two words come out in separate accesses, the counter may move between them. Rather than freezing a copy, the block watches each lower-then-upper read pair and reports in a status bit whether that pair was coherent.

A pair is not coherent if a trap event (an interrupt or exception being taken) arrives after the lower read. It is also not coherent if a carry from the lower word into the upper word happens after the lower word was sampled and before the upper word is read. Software reads lower, then upper, then the status. It repeats the sequence until the status bit is set. A control register turns counting on and off.

With the default `DATA_W` of 32 the counter is 64 bits wide and the status flag is bit 31 of the control word. Every register read returns its value in the same cycle as the access.

Top module: `wide_cycle_counter`

## Requirements
- R1: After reset the counter is zero, counting is off, and the control word reads zero (status bit and enable bit both clear).
- R2: A write to address 0x103 sets the enable from data bit 0. A read of 0x103 returns the enable in bit 0, and the change takes effect from the next cycle.
- R3: While enabled the 2*DATA_W-bit counter advances by one every clock, and a carry passes from the lower word into the upper word. While disabled it holds its value.
- R4: A read of 0x104 returns counter bits DATA_W-1:0 and a read of 0x105 returns bits 2*DATA_W-1:DATA_W, both in the cycle of the access.
- R5: A lower read followed later by an upper read, with no failure condition in between, sets the status bit (bit DATA_W-1 of the control word). Other register reads in between do not break the pair.
- R6: A trap event in any cycle after the lower-read cycle, up to and including the upper-read cycle, leaves the status bit clear. A trap event in the lower-read cycle itself is ignored.
- R7: A carry into the upper word at the clock edge that ends the lower-read cycle, or at any later edge before the upper-read cycle, leaves the status bit clear. A carry at the edge that ends the upper-read cycle does not.
- R8: An upper read that has no lower read pending, including a second upper read after a completed pair, clears the status bit.
- R9: Every lower read clears the status bit and starts a new pair.
- R10: Writes to 0x104 or 0x105 leave the counter unchanged, and a read of any unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Register address |
| wdata_i | input | DATA_W | Write data |
| trap_evt_i | input | 1 | An interrupt or exception is being taken this cycle |
| rdata_o | output | DATA_W | Read data, valid in the cycle of the read strobe, zero otherwise |

## Verification
The hardest case to reach from the ports is a carry into the upper word that lands inside a read pair. At full width this needs billions of cycles. The bench therefore builds the block with an 8-bit word, so the lower word wraps every 256 cycles. A reference model tracks the lower word, and the bench waits until that word sits one or zero steps below all-ones before it starts a pair. This places the carry on the lower-read edge, on an idle edge between the reads, and on the edge just after the upper read. Trap events are placed in the lower-read cycle, between the reads, and in the upper-read cycle.

// File: rtl/wcc_pkg.sv
package wcc_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 12'h103;
  localparam logic [ADDR_W-1:0] LO_ADDR   = 12'h104;
  localparam logic [ADDR_W-1:0] HI_ADDR   = 12'h105;

  typedef enum logic [1:0] {
    TRK_IDLE     = 2'd0,
    TRK_LOW_READ = 2'd1,
    TRK_DONE     = 2'd2
  } trk_state_e;
endpackage

// File: rtl/wcc_counter.sv
module wcc_counter #(
  parameter int unsigned LO_W = 32,
  localparam int unsigned CNT_W = 2 * LO_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hi_carry_o
);
  logic [LO_W-1:0] lo_q, hi_q;

  // upper word moves at the edge ending this cycle
  assign hi_carry_o = en_i && (&lo_q);
  assign cnt_o      = {hi_q, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (en_i) begin
      lo_q <= lo_q + 1'b1;
      if (hi_carry_o) hi_q <= hi_q + 1'b1;
    end
  end
endmodule

// File: rtl/wcc_read_tracker.sv
module wcc_read_tracker
  import wcc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_rd_i,
  input  logic hi_rd_i,
  input  logic trap_i,
  input  logic hi_carry_i,
  output logic ok_o,
  output logic pending_o
);
  trk_state_e state_q;
  logic       fail_q, ok_q;

  assign ok_o      = ok_q;
  assign pending_o = (state_q == TRK_LOW_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_IDLE;
      fail_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else if (lo_rd_i) begin
      state_q <= TRK_LOW_READ;
      fail_q  <= hi_carry_i;
      ok_q    <= 1'b0;
    end else if (hi_rd_i) begin
      if (state_q == TRK_LOW_READ) begin
        ok_q    <= !(fail_q || trap_i);
        state_q <= TRK_DONE;
      end else begin
        ok_q    <= 1'b0;
        state_q <= TRK_IDLE;
      end
    end else if (state_q == TRK_LOW_READ) begin
      fail_q <= fail_q || trap_i || hi_carry_i;
    end
  end
endmodule

// File: rtl/wide_cycle_counter.sv
module wide_cycle_counter
  import wcc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              trap_evt_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic             hi_carry, trk_ok, trk_pending;
  logic             lo_rd, hi_rd, ctrl_wr;
  logic             unused_wdata;

  assign lo_rd        = rd_en_i && (addr_i == LO_ADDR);
  assign hi_rd        = rd_en_i && (addr_i == HI_ADDR);
  assign ctrl_wr      = wr_en_i && (addr_i == CTRL_ADDR);
  assign unused_wdata = ^wdata_i[DATA_W-1:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= 1'b0;
    else if (ctrl_wr) en_q <= wdata_i[0];
  end

  wcc_counter #(.LO_W(DATA_W)) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .cnt_o      (cnt),
    .hi_carry_o (hi_carry)
  );

  wcc_read_tracker i_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lo_rd_i    (lo_rd),
    .hi_rd_i    (hi_rd),
    .trap_i     (trap_evt_i),
    .hi_carry_i (hi_carry),
    .ok_o       (trk_ok),
    .pending_o  (trk_pending)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        CTRL_ADDR: begin
          rdata_o[DATA_W-1] = trk_ok;
          rdata_o[0]        = en_q;
        end
        LO_ADDR:   rdata_o = cnt[DATA_W-1:0];
        HI_ADDR:   rdata_o = cnt[CNT_W-1:DATA_W];
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wcc_checker.sv
module wcc_checker
  import wcc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              trap_evt_i,
  input logic              en_q,
  input logic [CNT_W-1:0]  cnt,
  input logic              ok,
  input logic              pending
);
  logic lo_rd, hi_rd;
  assign lo_rd = rd_en_i && (addr_i == LO_ADDR);
  assign hi_rd = rd_en_i && (addr_i == HI_ADDR);

  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(cnt));

  a_r2_enable_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == CTRL_ADDR) |=> (en_q == $past(wdata_i[0])));

  a_r5_ok_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ok) |-> $past(hi_rd && pending));

  a_r6_trap_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && hi_rd && trap_evt_i) |=> !ok);

  a_r8_orphan_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_rd && !pending) |=> !ok);

  a_r9_low_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd |=> (!ok && pending));
endmodule

bind wide_cycle_counter wcc_checker #(.DATA_W(DATA_W)) i_wcc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .trap_evt_i (trap_evt_i),
  .en_q       (en_q),
  .cnt        (cnt),
  .ok         (trk_ok),
  .pending    (trk_pending)
);

// File: tb/test_wide_cycle_counter.sv
module test_wide_cycle_counter;
  import wcc_pkg::*;
  localparam int DW = 8;
  localparam int CW = 2 * DW;
  localparam longint LMASK = (64'd1 << DW) - 1;
  localparam longint CMASK = (64'd1 << CW) - 1;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              rd_en_i = 1'b0, wr_en_i = 1'b0, trap_evt_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DW-1:0]     wdata_i = '0;
  logic [DW-1:0]     rdata_o;

  int  n_chk = 0, n_fail = 0;
  bit  finished = 0;

  // reference model
  longint m_cnt = 0;
  bit     m_en = 0, m_fail = 0, m_ok = 0;
  int     m_phase = 0; // 0 none, 1 lower read pending, 2 pair done

  always #5ns clk_i = ~clk_i;

  wide_cycle_counter #(.DATA_W(DW)) i_wide_cycle_counter (
    .clk_i, .rst_ni, .rd_en_i, .wr_en_i, .addr_i, .wdata_i, .trap_evt_i, .rdata_o
  );

  function automatic logic [DW-1:0] exp_rdata(logic rd, logic [ADDR_W-1:0] a);
    logic [DW-1:0] v = '0;
    if (!rd) return '0;
    if (a == CTRL_ADDR) begin v[DW-1] = m_ok; v[0] = m_en; end
    else if (a == LO_ADDR) v = DW'(m_cnt & LMASK);
    else if (a == HI_ADDR) v = DW'((m_cnt >> DW) & LMASK);
    return v;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata actual %h expected %h (cnt model %h)", tag, act, exp, m_cnt);
    end
  endtask

  task automatic cyc(logic rd, logic wr, logic [ADDR_W-1:0] a, logic [DW-1:0] wd,
                     logic trap, string tag);
    bit carry, lo, hi;
    rd_en_i = rd; wr_en_i = wr; addr_i = a; wdata_i = wd; trap_evt_i = trap;
    #1ns;
    check(tag, rdata_o, exp_rdata(rd, a));
    carry = m_en && ((m_cnt & LMASK) == LMASK);
    lo = rd && (a == LO_ADDR);
    hi = rd && (a == HI_ADDR);
    @(posedge clk_i);
    #1ns;
    if (lo) begin m_phase = 1; m_fail = carry; m_ok = 0; end
    else if (hi) begin
      if (m_phase == 1) begin m_ok = !(m_fail || trap); m_phase = 2; end
      else begin m_ok = 0; m_phase = 0; end
    end else if (m_phase == 1) m_fail = m_fail || trap || carry;
    if (m_en) m_cnt = (m_cnt + 1) & CMASK;
    if (wr && a == CTRL_ADDR) m_en = wd[0];
    @(negedge clk_i);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, '0, 0, tag);
  endtask
  task automatic rd(logic [ADDR_W-1:0] a, string tag);
    cyc(1, 0, a, '0, 0, tag);
  endtask
  task automatic wait_low(longint v);
    while ((m_cnt & LMASK) != v) idle(1, "R3 wait");
  endtask
  task automatic expect_ok(bit e, string tag);
    check(tag, {m_ok, {(DW-1){1'b0}}}, {e, {(DW-1){1'b0}}});
    rd(CTRL_ADDR, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    rd(CTRL_ADDR, "R1 ctrl"); rd(LO_ADDR, "R1 low"); rd(HI_ADDR, "R1 high");
    // R3 disabled holds
    idle(3, "R3 idle"); rd(LO_ADDR, "R3 hold");
    // R2 enable
    cyc(0, 1, CTRL_ADDR, 8'h01, 0, "R2 write");
    rd(CTRL_ADDR, "R2 readback");
    idle(5, "R3 run");
    rd(LO_ADDR, "R4 low"); rd(HI_ADDR, "R4 high");
    // R5 clean pairs
    wait_low(10); rd(LO_ADDR, "R5 low"); rd(HI_ADDR, "R5 high"); expect_ok(1, "R5 back-to-back");
    wait_low(20); rd(LO_ADDR, "R5 low"); idle(3, "R5 gap");
    rd(CTRL_ADDR, "R5 ctrl mid"); rd(HI_ADDR, "R5 high"); expect_ok(1, "R5 gapped");
    // R6 trap events
    wait_low(40); rd(LO_ADDR, "R6 low"); cyc(0, 0, '0, '0, 1, "R6 trap");
    rd(HI_ADDR, "R6 high"); expect_ok(0, "R6 trap between");
    wait_low(50); rd(LO_ADDR, "R6 low"); cyc(1, 0, HI_ADDR, '0, 1, "R6 trap on high");
    expect_ok(0, "R6 trap in high cycle");
    wait_low(60); cyc(1, 0, LO_ADDR, '0, 1, "R6 trap on low"); rd(HI_ADDR, "R6 high");
    expect_ok(1, "R6 trap in low cycle ignored");
    // R7 carry cases
    wait_low(LMASK - 1); rd(LO_ADDR, "R7 low"); idle(1, "R7 gap"); rd(HI_ADDR, "R7 high");
    expect_ok(0, "R7 carry between");
    wait_low(LMASK); rd(LO_ADDR, "R7 low at wrap"); rd(HI_ADDR, "R7 high");
    expect_ok(0, "R7 carry on low edge");
    wait_low(LMASK - 1); rd(LO_ADDR, "R7 low"); rd(HI_ADDR, "R7 high at wrap");
    expect_ok(1, "R7 carry after high");
    // R8 orphan upper reads
    rd(HI_ADDR, "R8 second high"); expect_ok(0, "R8 after done");
    wait_low(30); rd(HI_ADDR, "R8 orphan"); expect_ok(0, "R8 no low");
    // R9 lower read restarts
    wait_low(70); rd(LO_ADDR, "R9 low"); rd(HI_ADDR, "R9 high");
    rd(LO_ADDR, "R9 relow"); expect_ok(0, "R9 cleared");
    rd(HI_ADDR, "R9 high"); expect_ok(1, "R9 new pair");
    // R10 ignored writes, unmapped reads
    cyc(0, 1, LO_ADDR, 8'hAA, 0, "R10 write low");
    cyc(0, 1, HI_ADDR, 8'h55, 0, "R10 write high");
    rd(LO_ADDR, "R10 low after write"); rd(HI_ADDR, "R10 high after write");
    rd(12'h000, "R10 unmapped"); rd(12'h106, "R10 unmapped");
    // R2/R3 disable
    cyc(0, 1, CTRL_ADDR, 8'h00, 0, "R2 disable");
    rd(CTRL_ADDR, "R2 readback off"); idle(4, "R3 stopped");
    rd(LO_ADDR, "R3 held"); rd(HI_ADDR, "R3 held");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule